// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a 3-bit synchronous counter that walks a fixed loop of five codes in a non-binary order: 000, 010, 011, 101, 110, then back to 000. The state register drives the output directly, with no decode stage between them. Each of the three remaining codes leads into the loop within at most two enabled clocks. A code like that can be left behind at power-up or by an upset. The next-state logic is three explicit per-bit equations. With bit 2 as C, bit 1 as B and bit 0 as A, they are C+ = A, B+ = B' + A'C' and A+ = B·C'.

A count enable advances the state one step per clock. A synchronous active-high reset loads a parameterised initial code. A status output shows whether the present code belongs to the loop. The counter suits sequencing jobs where a short, repeating, glitch-free state pattern is wanted and any code, including an unused one, must lead back into the loop without outside help.

Top module: `seqcnt5`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes the parameter `INIT_CODE` (default 000). This holds whatever `cntEn` is doing.
- R2: With `rst` low and `cntEn` high, each rising edge moves `stateOut` along 000 → 010 → 011 → 101 → 110 → 000.
- R3: With `rst` low and `cntEn` low, `stateOut` keeps its value across the edge. This holds for valid and unused codes alike.
- R4: Unused code 001 moves to 110 on one enabled edge.
- R5: Unused code 100 moves to 010 on one enabled edge.
- R6: Unused code 111 moves to 100 on the first enabled edge and to 010 on the second. No code needs more than two enabled edges to reach the loop.
- R7: `inCycle` is 1 exactly when `stateOut` is one of 000, 010, 011, 101 or 110, and 0 for 001, 100 and 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `INIT_CODE` |
| cntEn | input | 1 | Advance one step per clock when high |
| stateOut | output | 3 | State register: bit 2 = C, bit 1 = B, bit 0 = A |
| inCycle | output | 1 | High when the state is a loop code |

## Verification
The bench builds four copies of the counter. One copy uses `INIT_CODE` = 000 for the normal loop. The other three use `INIT_CODE` set to 001, 100 and 111, so that reset itself places them on an unused code. This makes every recovery path, and its length in clocks, reachable through the ports alone, with no forcing and no extra load port. The same copies also show that a held enable freezes an unused code, and that the status flag reads low on each unused code.

// File: rtl/seqcnt5_pkg.sv
package seqcnt5_pkg;
  localparam int STATE_W = 3;
  localparam int BIT_C = 2;
  localparam int BIT_B = 1;
  localparam int BIT_A = 0;

  typedef logic [STATE_W-1:0] code_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadInit;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/seqcnt5_ctrl.sv
module seqcnt5_ctrl
  import seqcnt5_pkg::*;
(
  input  logic    rst,
  input  logic    cntEn,
  output strobe_t strobes
);
  // Reset wins over enable.
  always_comb begin
    strobes.loadInit = rst;
    strobes.advance  = cntEn & ~rst;
  end
endmodule

// File: rtl/seqcnt5_path.sv
module seqcnt5_path
  import seqcnt5_pkg::*;
#(
  parameter code_t INIT_CODE = '0
) (
  input  logic    clk,
  input  strobe_t strobes,
  output code_t   stateQ,
  output logic    legal
);
  code_t nextCode;
  logic  c, b, a;

  assign c = stateQ[BIT_C];
  assign b = stateQ[BIT_B];
  assign a = stateQ[BIT_A];

  // Per-bit next-state equations; the don't-care fill makes unused codes recover.
  always_comb begin
    nextCode        = '0;
    nextCode[BIT_C] = a;
    nextCode[BIT_B] = ~b | (~a & ~c);
    nextCode[BIT_A] = b & ~c;
  end

  always_ff @(posedge clk) begin
    if (strobes.loadInit)
      stateQ <= INIT_CODE;
    else if (strobes.advance)
      stateQ <= nextCode;
  end

  // Loop membership.
  always_comb begin
    unique case (stateQ)
      3'b000, 3'b010, 3'b011, 3'b101, 3'b110: legal = 1'b1;
      default:                                legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/seqcnt5.sv
module seqcnt5
  import seqcnt5_pkg::*;
#(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cntEn,
  output logic [2:0] stateOut,
  output logic       inCycle
);
  strobe_t strobes;
  code_t   stateQ;
  logic    legal;

  seqcnt5_ctrl u_ctrl (
    .rst     (rst),
    .cntEn   (cntEn),
    .strobes (strobes)
  );

  seqcnt5_path #(.INIT_CODE(INIT_CODE)) u_path (
    .clk     (clk),
    .strobes (strobes),
    .stateQ  (stateQ),
    .legal   (legal)
  );

  assign stateOut = stateQ;
  assign inCycle  = legal;
endmodule

// File: rtl/seqcnt5_chk.sv
module seqcnt5_chk #(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic       cntEn,
  input logic [2:0] stateOut,
  input logic       inCycle
);
  // R1: just out of reset, the initial code is present
  p_reset_load_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> stateOut == INIT_CODE);

  // R2: the loop wraps from its last code to its first
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cntEn && stateOut == 3'b110) |=> stateOut == 3'b000);

  // R2: a loop code stays inside the loop when stepped
  p_stay_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (cntEn && inCycle) |=> inCycle);

  // R3: enable low freezes the state
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cntEn |=> $stable(stateOut));

  // R4: 001 jumps into the loop at 110
  p_rec001_r4: assert property (@(posedge clk) disable iff (rst)
    (cntEn && stateOut == 3'b001) |=> stateOut == 3'b110);

  // R5: 100 jumps into the loop at 010
  p_rec100_r5: assert property (@(posedge clk) disable iff (rst)
    (cntEn && stateOut == 3'b100) |=> stateOut == 3'b010);

  // R6: an unused code is either fixed in one step or passes through 100
  p_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (cntEn && !inCycle) |=> (inCycle || stateOut == 3'b100));

  // R7: the flag is low on every unused code
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 3'b001 || stateOut == 3'b100 || stateOut == 3'b111) |-> !inCycle);
endmodule

bind seqcnt5 seqcnt5_chk #(.INIT_CODE(INIT_CODE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cntEn    (cntEn),
  .stateOut (stateOut),
  .inCycle  (inCycle)
);

// File: tb/seqcnt5_tb.sv
module seqcnt5_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cntEn = 1'b0;
  logic illEn = 1'b0;
  logic [2:0] stMain, st001, st100, st111;
  logic okMain, ok001, ok100, ok111;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seqcnt5 #(.INIT_CODE(3'b000)) u_dut (
    .clk(clk), .rst(rst), .cntEn(cntEn), .stateOut(stMain), .inCycle(okMain));
  seqcnt5 #(.INIT_CODE(3'b001)) u_dut001 (
    .clk(clk), .rst(rst), .cntEn(illEn), .stateOut(st001), .inCycle(ok001));
  seqcnt5 #(.INIT_CODE(3'b100)) u_dut100 (
    .clk(clk), .rst(rst), .cntEn(illEn), .stateOut(st100), .inCycle(ok100));
  seqcnt5 #(.INIT_CODE(3'b111)) u_dut111 (
    .clk(clk), .rst(rst), .cntEn(illEn), .stateOut(st111), .inCycle(ok111));

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One rising edge, then sample 1 ns later.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R1: reset with enable high still loads the initial code; R7 flags on unused codes
  task automatic testReset();
    @(negedge clk);
    rst = 1'b1; cntEn = 1'b1; illEn = 1'b1;
    tick(); tick();
    chk("R1 main init", stMain, 3'b000);
    chk("R1 init 001", st001, 3'b001);
    chk("R1 init 100", st100, 3'b100);
    chk("R1 init 111", st111, 3'b111);
    chk("R7 flag 000", {2'b0, okMain}, 3'b001);
    chk("R7 flag 001", {2'b0, ok001}, 3'b000);
    chk("R7 flag 100", {2'b0, ok100}, 3'b000);
    chk("R7 flag 111", {2'b0, ok111}, 3'b000);
    @(negedge clk);
    cntEn = 1'b0; illEn = 1'b0; rst = 1'b0;
  endtask

  // R2: full loop twice, R7 flag high throughout
  task automatic testLoop();
    logic [2:0] seq [5] = '{3'b010, 3'b011, 3'b101, 3'b110, 3'b000};
    @(negedge clk);
    cntEn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R2 loop step", stMain, seq[i % 5]);
      chk("R7 flag in loop", {2'b0, okMain}, 3'b001);
    end
    @(negedge clk);
    cntEn = 1'b0;
  endtask

  // R3: hold with enable low, on a valid code and on unused codes
  task automatic testHold();
    @(negedge clk);
    cntEn = 1'b1;
    tick(); tick();
    @(negedge clk);
    cntEn = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 hold valid", stMain, 3'b011);
      chk("R3 hold 001", st001, 3'b001);
      chk("R3 hold 100", st100, 3'b100);
      chk("R3 hold 111", st111, 3'b111);
    end
  endtask

  // R4 R5 R6: recovery paths and their lengths
  task automatic testRecover();
    @(negedge clk);
    illEn = 1'b1;
    tick();
    chk("R4 001 to 110", st001, 3'b110);
    chk("R5 100 to 010", st100, 3'b010);
    chk("R6 111 to 100", st111, 3'b100);
    chk("R6 111 not yet legal", {2'b0, ok111}, 3'b000);
    tick();
    chk("R6 111 legal after two", st111, 3'b010);
    chk("R6 flag after two", {2'b0, ok111}, 3'b001);
    chk("R4 continues to 000", st001, 3'b000);
    chk("R5 continues to 011", st100, 3'b011);
    @(negedge clk);
    illEn = 1'b0;
  endtask

  // R1: reset mid-loop with enable high returns to 000
  task automatic testMidReset();
    @(negedge clk);
    cntEn = 1'b1;
    tick(); tick();
    @(negedge clk);
    rst = 1'b1;
    tick();
    chk("R1 mid reset", stMain, 3'b000);
    chk("R1 mid reset 111", st111, 3'b111);
    @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R2 first step after reset", stMain, 3'b010);
    @(negedge clk);
    cntEn = 1'b0;
  endtask

  initial begin
    testReset();
    testLoop();
    testReset();
    testHold();
    testRecover();
    testReset();
    testMidReset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule